// File: doc/BRIEF.md
# Shadowed Nonvolatile Register Commit Controller

This block owns one configuration byte kept twice: a volatile working copy that drives the rest of the chip at once, and a nonvolatile backing copy that survives a warm reset. A serial bus front end, not part of this block, decodes transactions. It hands over four kinds of event: an acknowledged data byte aimed at the shadowed register, a write to the control byte, a START (including a repeated START), and a STOP. The controller decides whether a backing-copy write is scheduled, fires it at the STOP, and holds a busy flag while the write engine works.

The volatile copy follows every accepted data byte at once. The backing copy follows only when three things hold: the shadow-suppress bit is clear, the transaction ends with a STOP, and no write is in progress. A repeated START cancels a scheduled write, so the working value changes without paying the write time. After a warm reset the working copy is reloaded from the backing copy. A cold reset restores the backing copy to its factory value and clears the write-cycle count.

Top module: `nvs_commit_ctrl`

## Requirements
- R1: A data byte written to the shadowed register appears on `work_o` one clock after the write strobe, whatever the shadow-suppress bit holds.
- R2: With the shadow-suppress bit at 0, a register write followed by a STOP gives a one-cycle `nv_req_o` pulse one clock after the STOP cycle. In that same cycle `nv_data_o` holds the written byte.
- R3: With the shadow-suppress bit at 1, a register write followed by a STOP leaves `nv_data_o` and `commit_cnt_o` unchanged and gives no `nv_req_o`.
- R4: The shadow-suppress bit is bit SHADOW_BIT (default 7) of a control-byte write and is shown on `shadow_o`. It is 0 after every warm reset.
- R5: A START that arrives while a backing write is scheduled cancels it, and a later STOP then commits nothing.
- R6: `busy_o` rises in the cycle of the `nv_req_o` pulse and stays high for exactly BUSY_CYCLES clocks.
- R7: A register write with the shadow-suppress bit at 0 while `busy_o` is high still updates `work_o`. It pulses `reject_o` one clock later and schedules no backing write.
- R8: `commit_cnt_o` rises by exactly one for each `nv_req_o` pulse and never changes otherwise.
- R9: At the first clock after a warm reset is released, `work_o` takes the backing value. A write strobe in that cycle is ignored.
- R10: When several register writes arrive before one STOP, a single backing write occurs and it stores the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Warm reset, active low; clears the volatile state |
| cold_rst_n | input | 1 | Cold reset, active low; restores the backing copy and clears the count |
| wr_reg_i | input | 1 | Acknowledged data byte for the shadowed register |
| wr_ctrl_i | input | 1 | Acknowledged data byte for the control byte |
| wr_data_i | input | DATA_W | Data byte that goes with either write strobe |
| start_i | input | 1 | START or repeated START seen on the bus |
| stop_i | input | 1 | STOP seen on the bus |
| work_o | output | DATA_W | Volatile working byte; also the read value |
| shadow_o | output | 1 | Shadow-suppress bit |
| nv_data_o | output | DATA_W | Backing copy |
| nv_req_o | output | 1 | One-cycle request to the nonvolatile write engine |
| busy_o | output | 1 | Write in progress |
| reject_o | output | 1 | A backing write was refused because the block was busy |
| commit_cnt_o | output | CNT_W | Count of backing writes performed |

## Verification
The hardest case to reach is a register write that lands while the write timer is still running. It can only happen after a full commit has been set off and before BUSY_CYCLES clocks have passed. The stimulus therefore sends a STOP to set off a real commit and at once follows it with a new write and a second STOP inside the busy window. It then checks that the refused value never reaches the backing copy. Warm-reset recall is reached the same way: a committed value is built up first, then the shadow bit is set and the working byte is changed, so that the recall visibly restores a value that differs from both the factory value and the current working byte.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    EV_IDLE = 2'd0,
    EV_ARM  = 2'd1,
    EV_DROP = 2'd2,
    EV_FIRE = 2'd3
  } commit_ev_e;

  // Priority: a STOP with a scheduled write fires; any bus boundary
  // otherwise cancels; a fresh unsuppressed write while idle schedules.
  function automatic commit_ev_e decide_ev(input logic wr_hit,
                                           input logic suppress,
                                           input logic start,
                                           input logic stop,
                                           input logic pending,
                                           input logic busy);
    if (stop && pending && !busy)       return EV_FIRE;
    if ((start || stop) && pending)     return EV_DROP;
    if (wr_hit && !suppress && !busy)   return EV_ARM;
    return EV_IDLE;
  endfunction

  function automatic logic refuse(input logic wr_hit,
                                  input logic suppress,
                                  input logic busy);
    return wr_hit && !suppress && busy;
  endfunction

endpackage

// File: rtl/nvs_pending.sv
module nvs_pending #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  nvs_pkg::commit_ev_e ev,
  input  logic [DATA_W-1:0]   data,
  output logic                pending,
  output logic [DATA_W-1:0]   pdata
);
  import nvs_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      pdata   <= '0;
    end else begin
      unique case (ev)
        EV_ARM: begin
          pending <= 1'b1;
          pdata   <= data;
        end
        EV_DROP, EV_FIRE: pending <= 1'b0;
        default: pending <= pending;
      endcase
    end
  end
endmodule

// File: rtl/nvs_busy_timer.sv
module nvs_busy_timer #(
  parameter int BUSY_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy
);
  localparam int TW = $clog2(BUSY_CYCLES + 1);
  localparam logic [TW-1:0] LOAD = TW'(BUSY_CYCLES);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire)           left_q <= LOAD;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/nvs_backing.sv
module nvs_backing #(
  parameter int              DATA_W      = 8,
  parameter int              CNT_W       = 16,
  parameter logic [DATA_W-1:0] FACTORY_VAL = 8'h5A
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              commit,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] nv_q,
  output logic [CNT_W-1:0]  cycles_q
);
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      nv_q     <= FACTORY_VAL;
      cycles_q <= '0;
    end else if (commit) begin
      nv_q     <= data;
      cycles_q <= cycles_q + 1'b1;
    end
  end
endmodule

// File: rtl/nvs_commit_ctrl.sv
module nvs_commit_ctrl #(
  parameter int                DATA_W      = 8,
  parameter int                CNT_W       = 16,
  parameter int                BUSY_CYCLES = 40,
  parameter int                SHADOW_BIT  = 7,
  parameter logic [DATA_W-1:0] FACTORY_VAL = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cold_rst_n,
  input  logic              wr_reg_i,
  input  logic              wr_ctrl_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic [DATA_W-1:0] work_o,
  output logic              shadow_o,
  output logic [DATA_W-1:0] nv_data_o,
  output logic              nv_req_o,
  output logic              busy_o,
  output logic              reject_o,
  output logic [CNT_W-1:0]  commit_cnt_o
);
  import nvs_pkg::*;

  logic              recall_q;
  logic              shadow_q;
  logic              req_q;
  logic              rej_q;
  logic [DATA_W-1:0] work_q;

  // Named internal events, brought out for the checker.
  logic              recall_w;
  logic              wr_hit_w;
  logic              ctrl_hit_w;
  logic              pending_w;
  logic              busy_w;
  logic              fire_w;
  logic [DATA_W-1:0] pdata_w;
  logic [DATA_W-1:0] nv_w;
  commit_ev_e        ev_w;

  assign recall_w   = recall_q;
  assign wr_hit_w   = wr_reg_i  && !recall_q;
  assign ctrl_hit_w = wr_ctrl_i && !recall_q;
  assign ev_w       = decide_ev(wr_hit_w, shadow_q, start_i, stop_i,
                                pending_w, busy_w);
  assign fire_w     = (ev_w == EV_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recall_q <= 1'b1;
      work_q   <= '0;
      shadow_q <= 1'b0;
      req_q    <= 1'b0;
      rej_q    <= 1'b0;
    end else begin
      req_q <= fire_w;
      rej_q <= refuse(wr_hit_w, shadow_q, busy_w);
      if (recall_q) begin
        work_q   <= nv_w;
        recall_q <= 1'b0;
      end else begin
        if (wr_hit_w)   work_q   <= wr_data_i;
        if (ctrl_hit_w) shadow_q <= wr_data_i[SHADOW_BIT];
      end
    end
  end

  nvs_pending #(.DATA_W(DATA_W)) u_pending (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev_w),
    .data    (wr_data_i),
    .pending (pending_w),
    .pdata   (pdata_w)
  );

  nvs_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire_w),
    .busy  (busy_w)
  );

  nvs_backing #(
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W),
    .FACTORY_VAL (FACTORY_VAL)
  ) u_backing (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .commit     (fire_w),
    .data       (pdata_w),
    .nv_q       (nv_w),
    .cycles_q   (commit_cnt_o)
  );

  assign work_o    = work_q;
  assign shadow_o  = shadow_q;
  assign nv_data_o = nv_w;
  assign nv_req_o  = req_q;
  assign busy_o    = busy_w;
  assign reject_o  = rej_q;
endmodule

// File: rtl/nvs_commit_sva.sv
module nvs_commit_sva #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  parameter int BUSY_CYCLES = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cold_rst_n,
  input logic              wr_reg_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              stop_i,
  input logic              recall_w,
  input logic              fire_w,
  input logic [DATA_W-1:0] work_o,
  input logic [DATA_W-1:0] nv_data_o,
  input logic              nv_req_o,
  input logic              busy_o,
  input logic [CNT_W-1:0]  commit_cnt_o
);
  localparam int RW = $clog2(BUSY_CYCLES + 2);

  logic [RW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R1
  a_r1_work_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_reg_i && !recall_w) |-> work_o == $past(wr_data_i));

  // R2
  a_r2_req_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req_o |-> $past(stop_i));

  // R3
  a_r3_nv_only_on_req: assert property (@(posedge clk)
    disable iff (!rst_n || !cold_rst_n)
    !nv_req_o |-> $stable(nv_data_o));

  // R6
  a_r6_req_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req_o |-> busy_o);

  a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_q == RW'(BUSY_CYCLES));

  // R7
  a_r7_no_fire_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w |-> !busy_o);

  // R8
  a_r8_cnt_step: assert property (@(posedge clk)
    disable iff (!rst_n || !cold_rst_n)
    nv_req_o |-> commit_cnt_o == CNT_W'($past(commit_cnt_o) + 1'b1));

  a_r8_cnt_hold: assert property (@(posedge clk)
    disable iff (!rst_n || !cold_rst_n)
    !nv_req_o |-> $stable(commit_cnt_o));
endmodule

bind nvs_commit_ctrl nvs_commit_sva #(
  .DATA_W      (DATA_W),
  .CNT_W       (CNT_W),
  .BUSY_CYCLES (BUSY_CYCLES)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .cold_rst_n   (cold_rst_n),
  .wr_reg_i     (wr_reg_i),
  .wr_data_i    (wr_data_i),
  .stop_i       (stop_i),
  .recall_w     (recall_w),
  .fire_w       (fire_w),
  .work_o       (work_o),
  .nv_data_o    (nv_data_o),
  .nv_req_o     (nv_req_o),
  .busy_o       (busy_o),
  .commit_cnt_o (commit_cnt_o)
);

// File: tb/tb_nvs_commit_ctrl.sv
`timescale 1ns/1ps
module tb_nvs_commit_ctrl;
  localparam int BUSY = 40;
  localparam int FACT = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, cold_rst_n = 1'b0;
  logic       wr_reg_i = 0, wr_ctrl_i = 0, start_i = 0, stop_i = 0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] work_o, nv_data_o;
  logic       shadow_o, nv_req_o, busy_o, reject_o;
  logic [15:0] commit_cnt_o;

  always #10 clk = ~clk;

  nvs_commit_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n),
    .wr_reg_i(wr_reg_i), .wr_ctrl_i(wr_ctrl_i), .wr_data_i(wr_data_i),
    .start_i(start_i), .stop_i(stop_i),
    .work_o(work_o), .shadow_o(shadow_o), .nv_data_o(nv_data_o),
    .nv_req_o(nv_req_o), .busy_o(busy_o), .reject_o(reject_o),
    .commit_cnt_o(commit_cnt_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Behavioural reference model
  int m_work, m_nv, m_cnt, m_busy, m_pdata;
  bit m_shadow, m_pend, m_req, m_rej, m_recall;

  always @(posedge clk) begin
    bit fire;
    if (!cold_rst_n) begin m_nv = FACT; m_cnt = 0; end
    if (!rst_n) begin
      m_work = 0; m_shadow = 0; m_pend = 0; m_busy = 0;
      m_req = 0; m_rej = 0; m_recall = 1;
    end else begin
      bit hit;
      hit  = wr_reg_i && !m_recall;
      fire = stop_i && m_pend && (m_busy == 0);
      m_req = fire;
      m_rej = hit && !m_shadow && (m_busy > 0);
      if (fire) begin
        m_nv = m_pdata; m_cnt = (m_cnt + 1) % 65536; m_pend = 0;
      end else if ((start_i || stop_i) && m_pend) m_pend = 0;
      else if (hit && !m_shadow && m_busy == 0) begin
        m_pend = 1; m_pdata = wr_data_i;
      end
      if (fire) m_busy = BUSY; else if (m_busy > 0) m_busy--;
      if (m_recall) begin m_work = m_nv; m_recall = 0; end
      else begin
        if (wr_reg_i) m_work = wr_data_i;
        if (wr_ctrl_i) m_shadow = wr_data_i[7];
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && cold_rst_n && !done) begin
    chk("R1 work_o", work_o, m_work);
    chk("R2 nv_data_o", nv_data_o, m_nv);
    chk("R2 nv_req_o", nv_req_o, m_req);
    chk("R4 shadow_o", shadow_o, m_shadow);
    chk("R6 busy_o", busy_o, m_busy > 0);
    chk("R7 reject_o", reject_o, m_rej);
    chk("R8 commit_cnt_o", commit_cnt_o, m_cnt);
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      wr_reg_i = 0; wr_ctrl_i = 0; start_i = 0; stop_i = 0;
    end
  endtask
  task automatic wreg(int d);
    @(negedge clk); wr_reg_i = 1; wr_data_i = 8'(d);
    @(negedge clk); wr_reg_i = 0;
  endtask
  task automatic wctrl(int d);
    @(negedge clk); wr_ctrl_i = 1; wr_data_i = 8'(d);
    @(negedge clk); wr_ctrl_i = 0;
  endtask
  task automatic bus_start();
    @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
  endtask
  task automatic bus_stop();
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
  endtask

  initial begin
    int blen;
    idle(3);
    rst_n = 1; cold_rst_n = 1;
    idle(2);
    chk("R9 recall factory", work_o, FACT);
    chk("R4 shadow reset", shadow_o, 0);
    chk("R6 idle busy", busy_o, 0);

    // R2 / R8 / R6
    bus_start(); wreg(8'h35);
    chk("R1 immediate", work_o, 8'h35);
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    chk("R2 req pulse", nv_req_o, 1);
    chk("R2 committed", nv_data_o, 8'h35);
    chk("R8 count one", commit_cnt_o, 1);
    blen = 0;
    while (busy_o && blen < 1000) begin blen++; @(negedge clk); end
    chk("R6 busy length", blen, BUSY);

    // R3 suppressed
    wctrl(8'h80);
    chk("R4 shadow set", shadow_o, 1);
    bus_start(); wreg(8'h11); bus_stop(); idle(2);
    chk("R3 work updated", work_o, 8'h11);
    chk("R3 nv kept", nv_data_o, 8'h35);
    chk("R3 count kept", commit_cnt_o, 1);
    wctrl(8'h00);

    // R5 repeated START cancels
    bus_start(); wreg(8'h22); bus_start(); bus_stop(); idle(2);
    chk("R5 nv kept", nv_data_o, 8'h35);
    chk("R5 no busy", busy_o, 0);

    // R10 multi-write, last wins
    bus_start(); wreg(8'h01); wreg(8'h02); wreg(8'h03); bus_stop();
    chk("R10 last value", nv_data_o, 8'h03);
    chk("R10 one commit", commit_cnt_o, 2);

    // R7 write during busy
    bus_start();
    @(negedge clk); wr_reg_i = 1; wr_data_i = 8'h44;
    @(negedge clk); wr_reg_i = 0;
    chk("R7 work updated", work_o, 8'h44);
    chk("R7 reject pulse", reject_o, 1);
    bus_stop(); idle(BUSY + 4);
    chk("R7 nv kept", nv_data_o, 8'h03);
    chk("R7 count kept", commit_cnt_o, 2);

    // R9 warm reset recall, shadow cleared
    wctrl(8'h80); wreg(8'h77);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; wr_reg_i = 1; wr_data_i = 8'h99;
    @(negedge clk); wr_reg_i = 0;
    chk("R9 recall backing", work_o, 8'h03);
    chk("R4 shadow cleared", shadow_o, 0);
    idle(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule